// File: doc/BRIEF.md
# Timer Tick Prescaler and Divider

This block produces a one-cycle tick enable for each of five timer channels. Two 8-bit prescalers divide the system clock. The first serves channels 0 and 1, and the second serves channels 2, 3 and 4. Each channel has its own 4-bit source-select code. The code picks either a power-of-two division of the channel's prescaler output or the edges of an external clock. The tick enables drive the down-counters of a timer bank elsewhere in the chip.

Software programs two configuration registers through a single-cycle write port. The external clock inputs are asynchronous. Each one passes through a two-flop synchroniser and a rising-edge detector. A liveness monitor tracks each external clock. When an external clock has never toggled, or has stopped toggling, the channels that select it fall back to their prescaler. Changing a select code in the middle of a period may shorten or lengthen that one period.

Top module: `timer_tick_gen`

## Requirements
- R1: While `rst` is high, every tick output is low. Every tick output is still low in the cycle after `rst` falls, before the next clock edge.
- R2: The prescale register holds two fields. Bits 7:0 hold the value for channels 0 and 1, and bits 15:8 hold the value for channels 2 to 4. A prescaler with value N wraps once every N+1 clock cycles.
- R3: A new prescale value is first used after the next wrap of that prescaler. After reset both prescalers start from a value of 0 and begin a full interval at once.
- R4: Channel c's select code is held in bits 4c+3:4c of the select register. Codes 0 to 4 divide the prescaler wraps by 1, 2, 4, 8 and 16. Codes 8 to 15 divide by 1.
- R5: Codes 5, 6 and 7 choose an external clock: `ext_clk_a` for channels 0 and 1, and `ext_clk_b` for channels 2 to 4. The channel ticks once for each rising edge of that clock. The tick is high in the cycle after clock edge k+2, where k is the first edge that samples the input high.
- R6: An external clock is live from its first detected rising edge until 64 consecutive cycles pass with no detected edge. While the clock it selects is not live, a channel with code 5, 6 or 7 ticks on every wrap of its prescaler. This includes the time from reset until the first edge.
- R7: A write with `wr_en` high and `wr_sel` 0 loads the prescale register from `wr_data[15:0]`. A write with `wr_sel` 1 loads the select register from `wr_data[19:0]`. While `wr_en` is low, `wr_data` and `wr_sel` have no effect.
- R8: Every tick output is registered. A tick is high in the cycle after the clock edge at which its source event was present: a prescaler-divider wrap or a detected external edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 prescale, 1 source select |
| wr_data | input | 20 | Write data |
| ext_clk_a | input | 1 | External clock for channels 0 and 1 |
| ext_clk_b | input | 1 | External clock for channels 2 to 4 |
| tick_o | output | 5 | One-cycle tick enable per channel |

## Verification
The bench carries a behavioural model of the block. It compares every tick output against that model on every clock.

Each internal fault shows up at the ports within a bounded time:
- A prescaler counter or latched reload value that is off by one moves the ticks of a whole channel group within one prescale interval.
- A divider count that drifts puts the spacing of one channel's ticks out of step by its next wrap.
- A liveness flag with the wrong value changes a channel's output from external-edge ticks to prescaler ticks, or the reverse, within one prescaler wrap or one external edge.
- A synchroniser stage that is lost or doubled shifts each external tick by one cycle at the first edge.

// File: rtl/tick_gen_pkg.sv
package tick_gen_pkg;

    localparam int SEL_BITS  = 4;
    localparam int MAX_SHIFT = 4;
    localparam int SHIFT_W   = 3;

    typedef enum logic {
        CFG_PRESCALE = 1'b0,
        CFG_SOURCE   = 1'b1
    } cfg_reg_e;

    typedef struct packed {
        logic               use_ext;
        logic [SHIFT_W-1:0] shift;
    } src_sel_t;

    function automatic src_sel_t decode_sel(input logic [SEL_BITS-1:0] code);
        src_sel_t s;
        s.use_ext = 1'b0;
        s.shift   = '0;
        case (code)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd4: s.shift = code[SHIFT_W-1:0];
            4'd5, 4'd6, 4'd7:             s.use_ext = 1'b1;
            default:                      s.shift = '0;
        endcase
        return s;
    endfunction

    function automatic logic [MAX_SHIFT-1:0] div_mask(input logic [SHIFT_W-1:0] shift);
        return ~({MAX_SHIFT{1'b1}} << shift);
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PRE_W-1:0] reload_val,
    output logic             pre_tick
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] act_q;

    assign pre_tick = (cnt_q == act_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= '0;
        end else if (pre_tick) begin
            cnt_q <= '0;
            act_q <= reload_val;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: the counter restarts right after every wrap
    a_r3_wrap_restart: assert property (@(posedge clk) disable iff (rst)
        pre_tick |=> (cnt_q == '0));

    // R2: the count never passes the value latched for this interval
    a_r2_count_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= act_q);

endmodule

// File: rtl/tick_ext_monitor.sv
module tick_ext_monitor #(
    parameter int STALL_LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_in,
    output logic edge_o,
    output logic live_o
);
    localparam int SC_W = $clog2(STALL_LIMIT + 1);
    localparam logic [SC_W-1:0] LIMIT_V = SC_W'(STALL_LIMIT);

    logic            sync1_q, sync2_q, hist_q;
    logic [SC_W-1:0] quiet_q, quiet_d;
    logic            alive_q, alive_d;

    assign edge_o = sync2_q & ~hist_q;
    assign live_o = alive_q | edge_o;

    always_comb begin
        if (edge_o)
            quiet_d = '0;
        else if (quiet_q == LIMIT_V)
            quiet_d = LIMIT_V;
        else
            quiet_d = quiet_q + 1'b1;

        if (edge_o)
            alive_d = 1'b1;
        else if (quiet_d == LIMIT_V)
            alive_d = 1'b0;
        else
            alive_d = alive_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            hist_q  <= 1'b0;
            quiet_q <= LIMIT_V;
            alive_q <= 1'b0;
        end else begin
            sync1_q <= ext_in;
            sync2_q <= sync1_q;
            hist_q  <= sync2_q;
            quiet_q <= quiet_d;
            alive_q <= alive_d;
        end
    end

    // R5: a detected edge is never two cycles wide
    a_r5_edge_isolated: assert property (@(posedge clk) disable iff (rst)
        edge_o |=> !edge_o);

    // R6: an edge makes the clock live
    a_r6_edge_revives: assert property (@(posedge clk) disable iff (rst)
        edge_o |=> alive_q);

    // R6: a full quiet window means not live
    a_r6_idle_timeout: assert property (@(posedge clk) disable iff (rst)
        (quiet_q == LIMIT_V) |-> !alive_q);

endmodule

// File: rtl/tick_chan_div.sv
module tick_chan_div
    import tick_gen_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               pre_tick,
    input  logic [SHIFT_W-1:0] shift,
    output logic               div_tick
);
    logic [MAX_SHIFT-1:0] dcnt_q;
    logic [MAX_SHIFT-1:0] mask;
    logic                 at_top;

    assign mask     = div_mask(shift);
    assign at_top   = (dcnt_q >= mask);
    assign div_tick = pre_tick & at_top;

    always_ff @(posedge clk) begin
        if (rst)
            dcnt_q <= '0;
        else if (pre_tick)
            dcnt_q <= at_top ? '0 : dcnt_q + 1'b1;
    end

    // R4: the count moves only on prescaler wraps
    a_r4_count_on_wrap: assert property (@(posedge clk) disable iff (rst)
        !pre_tick |=> $stable(dcnt_q));

endmodule

// File: rtl/timer_tick_gen.sv
module timer_tick_gen
    import tick_gen_pkg::*;
#(
    parameter int NUM_CH       = 5,
    parameter int LOW_GROUP_CH = 2,
    parameter int PRE_W        = 8,
    parameter int SEL_W        = SEL_BITS,
    parameter int STALL_LIMIT  = 64,
    localparam int PRE_BITS    = 2 * PRE_W,
    localparam int SRC_BITS    = NUM_CH * SEL_W,
    localparam int WR_W        = (PRE_BITS > SRC_BITS) ? PRE_BITS : SRC_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [WR_W-1:0]   wr_data,
    input  logic              ext_clk_a,
    input  logic              ext_clk_b,
    output logic [NUM_CH-1:0] tick_o
);
    localparam int NUM_GRP = 2;

    logic [PRE_BITS-1:0] pre_cfg_q;
    logic [SRC_BITS-1:0] src_cfg_q;
    logic [NUM_GRP-1:0]  grp_pre_tick;
    logic [NUM_GRP-1:0]  grp_edge;
    logic [NUM_GRP-1:0]  grp_live;
    logic [NUM_GRP-1:0]  ext_vec;
    logic [NUM_CH-1:0]   div_tick;
    logic [NUM_CH-1:0]   tick_d;
    logic [NUM_CH-1:0]   tick_q;

    assign ext_vec = {ext_clk_b, ext_clk_a};

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cfg_q <= '0;
            src_cfg_q <= '0;
        end else if (wr_en) begin
            if (cfg_reg_e'(wr_sel) == CFG_SOURCE)
                src_cfg_q <= wr_data[SRC_BITS-1:0];
            else
                pre_cfg_q <= wr_data[PRE_BITS-1:0];
        end
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        tick_prescaler #(.PRE_W(PRE_W)) u_pre (
            .clk        (clk),
            .rst        (rst),
            .reload_val (pre_cfg_q[g*PRE_W +: PRE_W]),
            .pre_tick   (grp_pre_tick[g])
        );
        tick_ext_monitor #(.STALL_LIMIT(STALL_LIMIT)) u_ext (
            .clk    (clk),
            .rst    (rst),
            .ext_in (ext_vec[g]),
            .edge_o (grp_edge[g]),
            .live_o (grp_live[g])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int GRP = (c < LOW_GROUP_CH) ? 0 : 1;
        src_sel_t sel;
        assign sel = decode_sel(src_cfg_q[c*SEL_W +: SEL_W]);

        tick_chan_div u_div (
            .clk      (clk),
            .rst      (rst),
            .pre_tick (grp_pre_tick[GRP]),
            .shift    (sel.shift),
            .div_tick (div_tick[c])
        );

        assign tick_d[c] = (sel.use_ext && grp_live[GRP]) ? grp_edge[GRP] : div_tick[c];

        // R8: every tick traces back to a wrap or an external edge one cycle earlier
        a_r8_tick_source: assert property (@(posedge clk) disable iff (rst)
            tick_q[c] |-> $past(grp_pre_tick[GRP] | grp_edge[GRP]));
    end

    always_ff @(posedge clk) begin
        if (rst)
            tick_q <= '0;
        else
            tick_q <= tick_d;
    end

    assign tick_o = tick_q;

endmodule

// File: tb/timer_tick_gen_bench.sv
module timer_tick_gen_bench;
    localparam int NCH   = 5;
    localparam int LIMIT = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [19:0] wr_data = '0;
    logic        ext_clk_a = 1'b0;
    logic        ext_clk_b = 1'b0;
    logic [4:0]  tick_o;

    always #5 clk = ~clk;

    timer_tick_gen u_timer_tick_gen (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ext_clk_a(ext_clk_a), .ext_clk_b(ext_clk_b), .tick_o(tick_o)
    );

    int    vectors = 0;
    int    miscompares = 0;
    int    cycle = 0;
    bit    cmp_on = 0;
    string cur_req = "R1";

    // behavioural reference state
    int pcnt[2], pact[2], dcnt[NCH];
    int s1[2], s2[2], s3[2], quiet[2], alive[2];
    int m_pre, m_src;
    bit exp_tick[NCH];

    always @(posedge clk) begin
        int ptick[2], edg[2], live[2], ext_now[2];
        cycle++;
        ext_now[0] = int'(ext_clk_a);
        ext_now[1] = int'(ext_clk_b);
        if (rst) begin
            for (int g = 0; g < 2; g++) begin
                pcnt[g] = 0; pact[g] = 0; s1[g] = 0; s2[g] = 0; s3[g] = 0;
                quiet[g] = LIMIT; alive[g] = 0;
            end
            for (int c = 0; c < NCH; c++) begin dcnt[c] = 0; exp_tick[c] = 0; end
            m_pre = 0; m_src = 0;
        end else begin
            for (int g = 0; g < 2; g++) begin
                ptick[g] = (pcnt[g] == pact[g]);
                edg[g]   = (s2[g] == 1 && s3[g] == 0);
                live[g]  = alive[g] | edg[g];
            end
            for (int c = 0; c < NCH; c++) begin
                int g, code, sh, lim;
                g = (c < 2) ? 0 : 1;
                code = (m_src >> (4 * c)) & 15;
                sh = (code <= 4) ? code : 0;
                lim = (1 << sh) - 1;
                if (code >= 5 && code <= 7 && live[g] != 0)
                    exp_tick[c] = (edg[g] != 0);
                else
                    exp_tick[c] = (ptick[g] != 0) && (dcnt[c] >= lim);
                if (ptick[g] != 0) dcnt[c] = (dcnt[c] >= lim) ? 0 : dcnt[c] + 1;
            end
            for (int g = 0; g < 2; g++) begin
                if (ptick[g] != 0) begin
                    pcnt[g] = 0;
                    pact[g] = (m_pre >> (8 * g)) & 255;
                end else pcnt[g] = pcnt[g] + 1;
                if (edg[g] != 0) begin quiet[g] = 0; alive[g] = 1; end
                else begin
                    if (quiet[g] < LIMIT) quiet[g] = quiet[g] + 1;
                    if (quiet[g] == LIMIT) alive[g] = 0;
                end
                s3[g] = s2[g]; s2[g] = s1[g]; s1[g] = ext_now[g];
            end
            if (wr_en) begin
                if (wr_sel) m_src = int'(wr_data);
                else        m_pre = int'(wr_data[15:0]);
            end
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            for (int c = 0; c < NCH; c++) begin
                vectors++;
                if (tick_o[c] !== exp_tick[c]) begin
                    miscompares++;
                    $display("FAIL %s ch%0d tick got %b expected %b at cycle %0d",
                             cur_req, c, tick_o[c], exp_tick[c], cycle);
                end
            end
        end
    end

    // external clock drivers: half-period in cycles, 0 holds the level
    int ha = 0, hb = 0, ca = 0, cb = 0;
    always @(negedge clk) begin
        if (ha > 0) begin ca++; if (ca >= ha) begin ca = 0; ext_clk_a = ~ext_clk_a; end end
        if (hb > 0) begin cb++; if (cb >= hb) begin cb = 0; ext_clk_b = ~ext_clk_b; end end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic s, input logic [19:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = ~s; wr_data = 20'hFFFFF; // R7: ignored while wr_en low
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired at cycle %0d got running expected finished", cycle);
        finish_run();
    end

    initial begin
        // R1: outputs low during reset
        repeat (4) begin
            @(negedge clk);
            vectors++;
            if (tick_o !== 5'b0) begin
                miscompares++;
                $display("FAIL R1 reset tick got %b expected 00000", tick_o);
            end
        end
        @(negedge clk);
        rst = 1'b0;
        vectors++;
        if (tick_o !== 5'b0) begin
            miscompares++;
            $display("FAIL R1 first cycle after reset got %b expected 00000", tick_o);
        end
        cmp_on = 1;

        cur_req = "R3"; run(12);               // defaults: every cycle
        cur_req = "R2"; wr(1'b0, 20'h00603);
        cur_req = "R4"; wr(1'b1, 20'h94210);   // ch0..ch4 codes 0,1,2,4,9
        run(400);
        cur_req = "R3"; wr(1'b0, 20'h00601);   // mid-interval change
        run(120);
        wr(1'b0, 20'h00014);
        run(300);
        cur_req = "R7"; run(60);
        cur_req = "R6"; wr(1'b0, 20'h00201);
        wr(1'b1, 20'h36715);                    // ch0=5 ch1=1 ch2=7 ch3=6 ch4=3
        run(100);                               // both external clocks absent
        cur_req = "R5"; ha = 5; run(200);
        hb = 4; run(200);
        cur_req = "R6"; hb = 0; run(150);       // B stops: fallback after 64 cycles
        cur_req = "R5"; ha = 1; run(100);
        cur_req = "R6"; ha = 0; run(120);
        cur_req = "R8"; wr(1'b1, 20'h00000); run(40);
        cmp_on = 0;
        @(negedge clk);
        finish_run();
    end

endmodule